// File: doc/BRIEF.md
# Paging Sync and Address Detect Controller

This block sits behind a paging receiver's bit slicer. It watches a serial bit stream, with one bit presented on each cycle that the bit strobe is high. It finds the batch synchronisation codeword and then keeps a bit counter aligned to batch and codeword boundaries. Once aligned, it looks for the station's own address codeword in the two codeword slots of its assigned frame. Both comparisons are Hamming-distance checks that accept up to two flipped bits.

Three outputs report progress toward a host. A sync-valid level covers the whole batch that follows an accepted sync word. An address-detect level covers one codeword period, or two periods when the address sat in the second slot of the frame. The receiver mode (searching, locked or coasting) is also brought out. A rising edge on the break input cancels an address-detect level that is in progress. The block then waits for the next address slot or sync window.

Top module: `pager_sync_detect`

## Requirements
- R1: After reset, syncValid and addrDetect are low and rxMode reads 0 (searching). The other encodings are 1 (locked) and 2 (coasting).
- R2: While searching, each strobed bit ends a 32-bit window. The first bit received is the most significant. If the window is within two bit flips of 0x7CD215D8, rxMode goes to 1 and syncValid goes high after that strobe.
- R3: A window that differs from the sync word in three or more bits is not accepted, and rxMode stays 0.
- R4: While locked, the sync word is checked again exactly 544 strobed bits after the previous sync window ended. A hit keeps syncValid high without a gap.
- R5: A sync miss while locked sets rxMode to 2 and drops syncValid. In state 2, a hit at the next window returns to 1 with syncValid high, and a miss returns to 0.
- R6: While locked, codeword k is counted from 0 after the sync window. Codewords 2f and 2f+1 belong to frame f, where f is frameSel. If such a codeword has bit 31 equal to 0 and its bits 30..13 are within two flips of addrIn, addrDetect is high for the next 32 strobed bits.
- R7: If the match is in the second codeword (2f+1), addrDetect stays high for 64 strobed bits.
- R8: No detection occurs for a codeword with bit 31 set, for three or more address errors, for a codeword outside the assigned frame, or while in state 2.
- R9: A rising edge on breakIn drops addrDetect at the third clock edge after the edge is sampled, and takes priority over a match in that cycle. Later address slots still detect.
- R10: Cycles with bitValid low change neither the window, the counter, syncValid nor rxMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Strobe: bitIn carries a new received bit |
| bitIn | input | 1 | Received bit |
| frameSel | input | 3 | Assigned frame number |
| addrIn | input | 18 | Station address |
| breakIn | input | 1 | Asynchronous abort request, rising-edge active |
| syncValid | output | 1 | High for the batch following an accepted sync |
| addrDetect | output | 1 | High after a matching address codeword |
| rxMode | output | 2 | 0 searching, 1 locked, 2 coasting |

## Verification
On every cycle the assertions check the following. The mode code is always legal. syncValid agrees with the locked state. Nothing moves on cycles without a strobe. addrDetect can only rise from the locked state on a strobe. A break edge forces addrDetect low three clocks later. The 544-bit batch alignment, the 32- versus 64-bit stretch, and the exact error-count thresholds depend on long bit sequences. Only the bench scenarios, compared against the reference model, can show these.

// File: rtl/pager_pkg.sv
package pager_pkg;
  typedef enum logic [1:0] {
    MODE_SEARCH = 2'd0,
    MODE_LOCK   = 2'd1,
    MODE_COAST  = 2'd2
  } rxMode_e;

  typedef struct packed {
    logic bitStep;
    logic cntRestart;
  } ctlStrobe_t;

  typedef struct packed {
    logic syncHit;
    logic syncSlot;
    logic addrHit;
    logic secondCw;
  } dpFlags_t;
endpackage

// File: rtl/pager_datapath.sv
module pager_datapath
  import pager_pkg::*;
#(
  parameter int CW_BITS      = 32,
  parameter int CW_PER_FRAME = 2,
  parameter int FRAMES       = 8,
  parameter int ADDR_W       = 18,
  parameter int FRAME_W      = 3,
  parameter int MAX_ERR      = 2,
  parameter logic [CW_BITS-1:0] SYNC_WORD = 32'h7CD215D8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic [FRAME_W-1:0] frameSel,
  input  logic [ADDR_W-1:0]  addrIn,
  input  ctlStrobe_t         strobe,
  output dpFlags_t           flags
);
  localparam int BATCH_BITS = CW_BITS * (CW_PER_FRAME * FRAMES + 1);
  localparam int CNT_W      = $clog2(BATCH_BITS);
  localparam int CW_LOG     = $clog2(CW_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BATCH_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(CW_BITS * CW_PER_FRAME * FRAMES);

  logic [CW_BITS-1:0] shiftQ, shiftD;
  logic [CNT_W-1:0]   cntQ;
  logic               cwEnd, inFrame;
  int                 cwIdx;

  assign shiftD = {shiftQ[CW_BITS-2:0], bitIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      cntQ   <= '0;
    end else if (strobe.bitStep) begin
      shiftQ <= shiftD;
      if (strobe.cntRestart || cntQ == LAST_BIT) cntQ <= '0;
      else                                       cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    cwIdx   = int'(cntQ >> CW_LOG);
    cwEnd   = (cntQ[CW_LOG-1:0] == '1) && (cntQ < FRAME_END);
    inFrame = (cwIdx / CW_PER_FRAME) == int'(frameSel);
    flags.syncHit  = $countones(shiftD ^ SYNC_WORD) <= MAX_ERR;
    flags.syncSlot = cntQ == LAST_BIT;
    flags.secondCw = (cwIdx % CW_PER_FRAME) == (CW_PER_FRAME - 1);
    flags.addrHit  = cwEnd && inFrame && !shiftD[CW_BITS-1] &&
                     ($countones(shiftD[CW_BITS-2 -: ADDR_W] ^ addrIn) <= MAX_ERR);
  end
endmodule

// File: rtl/pager_control.sv
module pager_control
  import pager_pkg::*;
#(
  parameter int CW_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       breakIn,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output logic       syncValid,
  output logic       addrDetect,
  output rxMode_e    rxMode
);
  localparam int HOLD_W = $clog2(2 * CW_BITS + 1);
  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(CW_BITS);
  localparam logic [HOLD_W-1:0] HOLD_TWO = HOLD_W'(2 * CW_BITS);

  rxMode_e           modeQ;
  logic              syncQ;
  logic [HOLD_W-1:0] holdQ;
  logic              brkMeta, brkSync, brkPrev, brkRise;

  assign brkRise           = brkSync && !brkPrev;
  assign strobe.bitStep    = bitValid;
  assign strobe.cntRestart = (modeQ == MODE_SEARCH) && flags.syncHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brkMeta <= 1'b0;
      brkSync <= 1'b0;
      brkPrev <= 1'b0;
    end else begin
      brkMeta <= breakIn;
      brkSync <= brkMeta;
      brkPrev <= brkSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_SEARCH;
      syncQ <= 1'b0;
    end else if (bitValid) begin
      unique case (modeQ)
        MODE_SEARCH: if (flags.syncHit) begin
          modeQ <= MODE_LOCK;
          syncQ <= 1'b1;
        end
        MODE_LOCK: if (flags.syncSlot && !flags.syncHit) begin
          modeQ <= MODE_COAST;
          syncQ <= 1'b0;
        end
        MODE_COAST: if (flags.syncSlot) begin
          modeQ <= flags.syncHit ? MODE_LOCK : MODE_SEARCH;
          syncQ <= flags.syncHit;
        end
        default: modeQ <= MODE_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         holdQ <= '0;
    else if (brkRise)  holdQ <= '0;
    else if (bitValid) begin
      if (modeQ == MODE_LOCK && flags.addrHit)
        holdQ <= flags.secondCw ? HOLD_TWO : HOLD_ONE;
      else if (holdQ != '0)
        holdQ <= holdQ - 1'b1;
    end
  end

  assign syncValid  = syncQ;
  assign addrDetect = holdQ != '0;
  assign rxMode     = modeQ;
endmodule

// File: rtl/pager_sync_detect.sv
module pager_sync_detect
  import pager_pkg::*;
#(
  parameter int CW_BITS      = 32,
  parameter int CW_PER_FRAME = 2,
  parameter int FRAMES       = 8,
  parameter int ADDR_W       = 18,
  parameter int FRAME_W      = 3,
  parameter int MAX_ERR      = 2,
  parameter logic [CW_BITS-1:0] SYNC_WORD = 32'h7CD215D8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic [FRAME_W-1:0] frameSel,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               breakIn,
  output logic               syncValid,
  output logic               addrDetect,
  output logic [1:0]         rxMode
);
  ctlStrobe_t strobe;
  dpFlags_t   flags;
  rxMode_e    modeEnum;

  pager_datapath #(
    .CW_BITS(CW_BITS), .CW_PER_FRAME(CW_PER_FRAME), .FRAMES(FRAMES),
    .ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .MAX_ERR(MAX_ERR), .SYNC_WORD(SYNC_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .frameSel(frameSel),
    .addrIn(addrIn), .strobe(strobe), .flags(flags)
  );

  pager_control #(.CW_BITS(CW_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .breakIn(breakIn),
    .flags(flags), .strobe(strobe), .syncValid(syncValid),
    .addrDetect(addrDetect), .rxMode(modeEnum)
  );

  assign rxMode = modeEnum;
endmodule

// File: rtl/pager_sync_detect_checker.sv
module pager_sync_detect_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bitValid,
  input logic       breakIn,
  input logic       syncValid,
  input logic       addrDetect,
  input logic [1:0] rxMode
);
  a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    rxMode != 2'd3);

  a_r4_sync_tracks_lock: assert property (@(posedge clk) disable iff (!rstN)
    syncValid == (rxMode == 2'd1));

  a_r10_idle_strobe_stable: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(syncValid) && $stable(rxMode));

  a_r2_sync_rise_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncValid) |-> $past(bitValid));

  a_r6_detect_from_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrDetect) |-> ($past(rxMode) == 2'd1) && $past(bitValid));

  a_r9_break_clears: assert property (@(posedge clk) disable iff (!rstN)
    ($past(breakIn, 3) && !$past(breakIn, 4)) |-> !addrDetect);
endmodule

bind pager_sync_detect pager_sync_detect_checker u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .breakIn(breakIn),
  .syncValid(syncValid), .addrDetect(addrDetect), .rxMode(rxMode)
);

// File: tb/pager_sync_detect_bench.sv
module pager_sync_detect_bench;
  localparam logic [31:0] SYNC = 32'h7CD215D8;
  localparam logic [17:0] ADDR = 18'h2A5C3;
  localparam logic [2:0]  FSEL = 3'd3;
  localparam logic [31:0] ADDR_CW = {1'b0, ADDR, 13'h0155};

  logic clk = 0, rstN = 0, bitValid = 0, bitIn = 0, breakIn = 0;
  logic [2:0] frameSel = FSEL;
  logic [17:0] addrIn = ADDR;
  logic syncValid, addrDetect;
  logic [1:0] rxMode;

  int checks = 0, fails = 0, bitNo = 0, cycles = 0;
  string phase = "R1";
  logic [31:0] words [16];

  // reference model state
  int mMode = 0, mHold = 0, mCnt = 0;
  logic mSv = 0, b1 = 0, b2 = 0, b3 = 0;
  logic [31:0] mWin = '0;

  always #2.5 clk = ~clk;

  pager_sync_detect u_pager_sync_detect (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .frameSel(frameSel), .addrIn(addrIn), .breakIn(breakIn),
    .syncValid(syncValid), .addrDetect(addrDetect), .rxMode(rxMode)
  );

  always @(posedge clk) begin
    logic rise, syncOk, addrOk, slot;
    int cw, nextCnt;
    cycles++;
    if (!rstN) begin
      mMode = 0; mSv = 0; mHold = 0; mCnt = 0; mWin = '0; b1 = 0; b2 = 0; b3 = 0;
    end else begin
      rise = b2 && !b3; b3 = b2; b2 = b1; b1 = breakIn;
      addrOk = 0; cw = 0;
      if (bitValid) begin
        mWin = {mWin[30:0], bitIn};
        syncOk = $countones(mWin ^ SYNC) <= 2;
        slot = (mCnt == 543);
        cw = mCnt / 32;
        if (mCnt < 512 && mCnt % 32 == 31)
          addrOk = (mMode == 1) && (cw / 2 == int'(frameSel)) && !mWin[31] &&
                   ($countones(mWin[30:13] ^ addrIn) <= 2);
        nextCnt = (mCnt == 543) ? 0 : mCnt + 1;
        case (mMode)
          0: if (syncOk) begin mMode = 1; mSv = 1; nextCnt = 0; end
          1: if (slot && !syncOk) begin mMode = 2; mSv = 0; end
          default: if (slot) begin mMode = syncOk ? 1 : 0; mSv = syncOk; end
        endcase
        mCnt = nextCnt;
      end
      if (rise) mHold = 0;
      else if (bitValid) begin
        if (addrOk) mHold = (cw % 2 == 1) ? 64 : 32;
        else if (mHold > 0) mHold--;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rstN) begin
    chk(syncValid == mSv, {phase, " syncValid"}, int'(syncValid), int'(mSv));
    chk(addrDetect == (mHold != 0), {phase, " addrDetect"}, int'(addrDetect), int'(mHold != 0));
    chk(int'(rxMode) == mMode, {phase, " rxMode"}, int'(rxMode), mMode);
  end

  task automatic sendBit(input logic b);
    @(negedge clk); bitValid = 1; bitIn = b;
    for (int g = 0; g < bitNo % 3; g++) begin @(negedge clk); bitValid = 0; end
    bitNo++;
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) sendBit(w[i]);
    @(negedge clk); bitValid = 0; bitIn = 0;
  endtask

  task automatic fillBatch();
    for (int k = 0; k < 16; k++) words[k] = 32'h8000_0000 | (k * 32'h0011_1111);
  endtask

  task automatic sendBody();
    for (int k = 0; k < 16; k++) sendWord(words[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!syncValid && !addrDetect && rxMode == 2'd0, "R1 reset", int'(rxMode), 0);
    rstN = 1;
    @(negedge clk);
    chk(rxMode == 2'd0, "R1 after release", int'(rxMode), 0);

    phase = "R3";
    sendWord(32'h1234_5678);
    sendWord(SYNC ^ 32'h0100_0101);
    chk(rxMode == 2'd0 && !syncValid, "R3 three-error sync", int'(rxMode), 0);

    phase = "R2";
    sendWord(SYNC ^ 32'h0000_0101);
    chk(rxMode == 2'd1 && syncValid, "R2 sync accepted", int'(syncValid), 1);

    phase = "R6";
    fillBatch();
    words[6] = ADDR_CW ^ 32'h0810_0000;
    for (int k = 0; k < 16; k++) begin
      sendWord(words[k]);
      if (k == 6) chk(addrDetect, "R6 first-slot detect", int'(addrDetect), 1);
      if (k == 7) chk(!addrDetect, "R6 one period only", int'(addrDetect), 0);
    end
    phase = "R4";
    sendWord(SYNC ^ 32'h0000_0020);
    chk(syncValid && rxMode == 2'd1, "R4 resync kept", int'(syncValid), 1);

    phase = "R7";
    fillBatch();
    words[7] = ADDR_CW;
    words[9] = ADDR_CW;
    for (int k = 0; k < 16; k++) begin
      sendWord(words[k]);
      if (k == 8) chk(addrDetect, "R7 second period held", int'(addrDetect), 1);
      if (k == 10) chk(!addrDetect, "R8 wrong frame ignored", int'(addrDetect), 0);
    end
    sendWord(SYNC);

    phase = "R9";
    fillBatch();
    words[6] = ADDR_CW;
    for (int k = 0; k < 16; k++) begin
      if (k == 7) begin
        fork
          sendWord(words[k]);
          begin repeat (20) @(negedge clk); breakIn = 1; repeat (6) @(negedge clk); breakIn = 0; end
        join
        chk(!addrDetect, "R9 break cleared", int'(addrDetect), 0);
      end else sendWord(words[k]);
    end
    phase = "R5";
    sendWord(SYNC ^ 32'h0007_0000);
    chk(rxMode == 2'd2 && !syncValid, "R5 lock to coast", int'(rxMode), 2);

    phase = "R8";
    fillBatch();
    words[6] = ADDR_CW;
    sendBody();
    chk(!addrDetect, "R8 coast ignores address", int'(addrDetect), 0);
    phase = "R5";
    sendWord(SYNC ^ 32'h8000_0000);
    chk(rxMode == 2'd1 && syncValid, "R5 coast to lock", int'(rxMode), 1);

    phase = "R8";
    fillBatch();
    words[6] = ADDR_CW ^ 32'h0001_C000;
    words[7] = ADDR_CW | 32'h8000_0000;
    sendBody();
    sendWord(SYNC);

    phase = "R9";
    fillBatch();
    words[6] = ADDR_CW;
    for (int k = 0; k < 16; k++) begin
      sendWord(words[k]);
      if (k == 6) chk(addrDetect, "R9 re-armed detect", int'(addrDetect), 1);
    end
    phase = "R5";
    sendWord(32'h0F0F_0F0F);
    chk(rxMode == 2'd2, "R5 miss to coast", int'(rxMode), 2);
    fillBatch();
    sendBody();
    sendWord(32'h0F0F_0F0F);
    chk(rxMode == 2'd0, "R5 coast to search", int'(rxMode), 0);

    phase = "R10";
    bitValid = 0; bitIn = 1;
    repeat (40) @(negedge clk);
    chk(rxMode == 2'd0 && !syncValid, "R10 no strobe no change", int'(rxMode), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule